// File: doc/BRIEF.md
# Selectable Clock Output Divider

This block produces a divided clock output from one of two timing sources. Both sources arrive as one-cycle enable pulses that are synchronous to a single fast system clock: a slow pulse train at 32768 Hz and a fast one near 4 MHz. A control word picks the source, a pre-divider that acts only on the fast source, a power-of-two post-divider, and an enable. The output is a register that toggles on source pulses, so the whole block runs on one clock and contains no derived clocks.

The total ratio is the pre-divider ratio times the post-divider ratio. The output stays low for half of that ratio, counted in selected source pulses, and then stays high for the other half. When the total ratio is 1, no division takes place. In that case the output carries a one-cycle copy of each selected pulse. New settings are applied only where a period of the output ends. Clearing the enable parks the output low. The control word is a plain level input with no handshake. Software may change it at any time.

Top module: `ckout_gen`

## Requirements
- R1: Control word layout: bit 0 enables the output, bits [3:1] hold the post-divider code, bit 4 selects the source (0 = `slow_tick`, 1 = `fast_tick`), and bits [7:5] hold the pre-divider code.
- R2: With the slow source and a post code k of 1 or more, each low phase and each high phase of `clk_out` lasts 2^(k-1) slow pulses.
- R3: With the fast source, the pre-divider ratio is 2^p for codes p = 0 to 6. The total ratio D is the pre ratio times 2^k, and each phase lasts D/2 fast pulses. With the slow source the pre-divider code has no effect.
- R4: Pre-divider code 7 divides by 122, so both the high phase and the low phase last 61·2^k fast pulses.
- R5: When the total ratio is 1, `clk_out` goes high for exactly one clock cycle, in the cycle after each selected pulse is sampled.
- R6: When bit 0 of the control word is sampled low, `clk_out` is low from the next cycle. It stays low, whatever the source pulses do, for as long as bit 0 stays low.
- R7: After the enable is set, `clk_out` starts low. Its first transition is a rise.
- R8: In divided mode, a change to the source or to either divider takes effect only at the source pulse that ends a high phase. In pass-through mode, a change takes effect only in a cycle with no selected pulse. The period in progress always finishes with the old settings.
- R9: Pulses on the source that is not selected have no effect on `clk_out`.
- R10: During reset and after reset, `clk_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl | input | 8 | Control word (fields in R1) |
| slow_tick | input | 1 | One-cycle pulse at the 32768 Hz rate |
| fast_tick | input | 1 | One-cycle pulse at the fast source rate |
| clk_out | output | 1 | Divided, gated output |

## Verification
The bench drives both pulse trains at once, at different fixed spacings, and measures the distance in cycles between successive output edges. Each measured gap must equal the phase length times the spacing of the selected source, which shows whether the right source and the right ratio were used.

The settings tried cover the slow source, including a case with the pre-divider code set high, and the fast source with power-of-two pre codes and with the 122 code. Pass-through is tried on both sources, which separates the one-cycle pulse behaviour from real division.

Settings are also changed while the output is running: once during a high phase and once during a low phase. These two cases show whether a change is held until the end of the high phase or is applied early. Two further changes, a source switch and a switch from divided mode to pass-through, test where the new setting starts.

// File: rtl/ckout_pkg.sv
package ckout_pkg;

  typedef enum logic {
    SRC_SLOW = 1'b0,
    SRC_FAST = 1'b1
  } ckout_src_e;

  // Pre-divider ratio: powers of two for every code but the top one,
  // which maps to a fixed non-power-of-two ratio.
  function automatic int unsigned pre_ratio(input int unsigned code,
                                            input int unsigned code_top,
                                            input int unsigned top_ratio);
    return (code == code_top) ? top_ratio : (32'd1 << code);
  endfunction

endpackage

// File: rtl/ckout_cfg.sv
module ckout_cfg
  import ckout_pkg::*;
#(
  parameter int PRE_W   = 3,
  parameter int POST_W  = 3,
  parameter int PRE_TOP = 122,
  parameter int DIV_W   = 14,
  parameter int HALF_W  = DIV_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PRE_W-1:0]  pre_code,
  input  logic              src_sel,
  input  logic [POST_W-1:0] post_code,
  input  logic              enable,
  output logic              run,
  output ckout_src_e        src,
  output logic              bypass,
  output logic [HALF_W-1:0] half
);

  localparam int unsigned PRE_CODE_TOP = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] ratio_pre;
  logic [DIV_W-1:0] ratio_all;

  // The slow source never passes through the pre-divider.
  always_comb begin
    if (src_sel == SRC_FAST)
      ratio_pre = DIV_W'(pre_ratio(32'(pre_code), PRE_CODE_TOP, PRE_TOP));
    else
      ratio_pre = DIV_W'(1);
    ratio_all = ratio_pre << post_code;
  end

  // Active settings: captured while idle or at a period boundary only.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      src    <= SRC_SLOW;
      bypass <= 1'b1;
      half   <= '0;
    end else if (load) begin
      run    <= enable;
      src    <= ckout_src_e'(src_sel);
      bypass <= (ratio_all == DIV_W'(1));
      half   <= ratio_all[DIV_W-1:1];
    end
  end

endmodule

// File: rtl/ckout_src_mux.sv
module ckout_src_mux #(
  parameter int N_SRC = 2,
  parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] ticks,
  input  logic [SEL_W-1:0] sel,
  input  logic             run,
  output logic             tick
);

  logic [N_SRC-1:0] gated;

  for (genvar i = 0; i < N_SRC; i++) begin : g_gate
    assign gated[i] = ticks[i] & (sel == SEL_W'(i));
  end

  assign tick = run & (|gated);

endmodule

// File: rtl/ckout_phase.sv
module ckout_phase #(
  parameter int HALF_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic              run,
  input  logic              bypass,
  input  logic [HALF_W-1:0] half,
  input  logic              tick,
  output logic              out_q,
  output logic              boundary
);

  logic [HALF_W-1:0] cnt;
  logic              last;

  assign last = (cnt == half - HALF_W'(1));

  // End of a period: the pulse that closes a high phase, or any
  // pulse-free cycle when running undivided.
  assign boundary = bypass ? ~tick : (tick & last & out_q);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_req || !run) begin
      cnt   <= '0;
      out_q <= 1'b0;
    end else if (bypass) begin
      cnt   <= '0;
      out_q <= tick;
    end else if (tick) begin
      if (last) begin
        cnt   <= '0;
        out_q <= ~out_q;
      end else begin
        cnt <= cnt + HALF_W'(1);
      end
    end
  end

  // R6: a cleared enable parks the output low on the next cycle
  p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_req |=> !out_q);

  // R8: in divided mode the output moves only on a source pulse
  p_runt_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && en_req && !bypass && !tick) |=> $stable(out_q));

  // R2: the phase counter never reaches the phase length
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bypass) |-> (cnt < half));

endmodule

// File: rtl/ckout_gen.sv
module ckout_gen
  import ckout_pkg::*;
#(
  parameter int PRE_W   = 3,
  parameter int POST_W  = 3,
  parameter int PRE_TOP = 122
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PRE_W+POST_W+1:0]   ctrl,
  input  logic                      slow_tick,
  input  logic                      fast_tick,
  output logic                      clk_out
);

  localparam int ENA_BIT   = 0;
  localparam int POST_LSB  = 1;
  localparam int SRC_BIT   = POST_W + 1;
  localparam int PRE_LSB   = POST_W + 2;
  localparam int MAX_RATIO = PRE_TOP << ((1 << POST_W) - 1);
  localparam int DIV_W     = $clog2(MAX_RATIO + 1);
  localparam int HALF_W    = DIV_W - 1;

  logic              run_w;
  ckout_src_e        src_w;
  logic              bypass_w;
  logic [HALF_W-1:0] half_w;
  logic              tick_w;
  logic              boundary_w;
  logic              load_w;
  logic [1:0]        ticks_w;

  assign ticks_w = {fast_tick, slow_tick};
  assign load_w  = ~ctrl[ENA_BIT] | ~run_w | boundary_w;

  ckout_cfg #(
    .PRE_W   (PRE_W),
    .POST_W  (POST_W),
    .PRE_TOP (PRE_TOP),
    .DIV_W   (DIV_W),
    .HALF_W  (HALF_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_w),
    .pre_code  (ctrl[PRE_LSB +: PRE_W]),
    .src_sel   (ctrl[SRC_BIT]),
    .post_code (ctrl[POST_LSB +: POST_W]),
    .enable    (ctrl[ENA_BIT]),
    .run       (run_w),
    .src       (src_w),
    .bypass    (bypass_w),
    .half      (half_w)
  );

  ckout_src_mux #(
    .N_SRC (2),
    .SEL_W (1)
  ) u_mux (
    .ticks (ticks_w),
    .sel   (src_w),
    .run   (run_w),
    .tick  (tick_w)
  );

  ckout_phase #(
    .HALF_W (HALF_W)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_req   (ctrl[ENA_BIT]),
    .run      (run_w),
    .bypass   (bypass_w),
    .half     (half_w),
    .tick     (tick_w),
    .out_q    (clk_out),
    .boundary (boundary_w)
  );

  // R8: active settings change only while the output is low
  p_cfg_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(half_w) || !$stable(src_w)) |-> !clk_out);

endmodule

// File: tb/ckout_gen_tb.sv
module ckout_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int FAST_P     = 3;
  localparam int SLOW_P     = 37;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic       slow_tick = 1'b0;
  logic       fast_tick = 1'b0;
  logic       clk_out;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  int    exp_q[$];
  string req_q[$];
  bit    have_last = 1'b0;
  int    cyc = 0;
  int    last_edge = 0;
  logic  prev_out = 1'b0;
  int    e_v;
  string r_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  ckout_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .slow_tick (slow_tick),
    .fast_tick (fast_tick),
    .clk_out   (clk_out)
  );

  // Pulse generators for both sources, running all the time.
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      fast_tick = (c == 0);
      c = (c + 1) % FAST_P;
    end
  end

  initial begin
    int c = 5;
    forever begin
      @(negedge clk);
      slow_tick = (c == 0);
      c = (c + 1) % SLOW_P;
    end
  end

  task automatic check(input bit ok, input string req, input int act,
                       input int exp, input string what);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected gap per output edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n && (clk_out !== prev_out)) begin
      if (!have_last) begin
        check(clk_out === 1'b1, "R7", int'(clk_out), 1, "first edge after enable");
        have_last = 1'b1;
      end else if (exp_q.size() > 0) begin
        e_v = exp_q.pop_front();
        r_v = req_q.pop_front();
        if (e_v >= 0)
          check((cyc - last_edge) == e_v, r_v, cyc - last_edge, e_v, "edge spacing");
      end
      last_edge = cyc;
    end
    prev_out = clk_out;
  end

  function automatic logic [7:0] mk(input int pre, input int src,
                                    input int post, input int en);
    return {pre[2:0], src[0], post[2:0], en[0]};
  endfunction

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic push(input int n, input int val, input string req);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(val);
      req_q.push_back(req);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) step();
  endtask

  task automatic start_cfg(input logic [7:0] c);
    bit ok;
    step();
    ctrl = {ctrl[7:1], 1'b0};
    step();
    check(clk_out === 1'b0, "R6", int'(clk_out), 0, "low one cycle after disable");
    ok = 1'b1;
    for (int i = 0; i < 60; i++) begin
      step();
      if (clk_out !== 1'b0) ok = 1'b0;
    end
    check(ok, "R6", int'(ok), 1, "held low while disabled despite pulses");
    have_last = 1'b0;
    ctrl = c;
    step();
    check(clk_out === 1'b0, "R7", int'(clk_out), 0, "starts low after enable");
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) step();
    check(clk_out === 1'b0, "R10", int'(clk_out), 0, "low during reset");
    rst_n = 1'b1;
    step();
    check(clk_out === 1'b0, "R10", int'(clk_out), 0, "low after reset");

    // Slow source, divided (R2), pre code ignored (R3), bypass (R5)
    start_cfg(mk(0, 0, 1, 1)); push(4, SLOW_P, "R2"); drain();
    start_cfg(mk(0, 0, 3, 1)); push(4, 4 * SLOW_P, "R2"); drain();
    start_cfg(mk(7, 0, 1, 1)); push(3, SLOW_P, "R3"); drain();
    start_cfg(mk(0, 0, 0, 1)); push(1, 1, "R5"); push(1, SLOW_P - 1, "R5");
    push(1, 1, "R5"); push(1, SLOW_P - 1, "R5"); drain();

    // Fast source: unselected slow pulses ignored (R9), table (R3, R1), 122 (R4)
    start_cfg(mk(0, 1, 1, 1)); push(4, FAST_P, "R9"); drain();
    start_cfg(mk(0, 1, 2, 1)); push(4, 2 * FAST_P, "R3"); drain();
    start_cfg(8'h73);          push(4, 8 * FAST_P, "R1"); drain();
    start_cfg(mk(5, 1, 0, 1)); push(4, 16 * FAST_P, "R3"); drain();
    start_cfg(mk(7, 1, 0, 1)); push(4, 61 * FAST_P, "R4"); drain();
    start_cfg(mk(7, 1, 2, 1)); push(3, 244 * FAST_P, "R4"); drain();
    start_cfg(mk(0, 1, 0, 1)); push(1, 1, "R5"); push(1, FAST_P - 1, "R5");
    push(1, 1, "R5"); push(1, FAST_P - 1, "R5"); drain();

    // R8: change during a high phase
    start_cfg(mk(0, 1, 3, 1)); push(2, 4 * FAST_P, "R8"); drain();
    ctrl = mk(0, 1, 1, 1);
    push(1, 4 * FAST_P, "R8"); push(4, FAST_P, "R8"); drain();

    // R8: change during a low phase
    start_cfg(mk(0, 1, 3, 1)); push(3, 4 * FAST_P, "R8"); drain();
    ctrl = mk(4, 1, 0, 1);
    push(2, 4 * FAST_P, "R8"); push(3, 8 * FAST_P, "R8"); drain();

    // R8: source switch at a high phase
    start_cfg(mk(0, 1, 1, 1)); push(2, FAST_P, "R8"); drain();
    ctrl = mk(0, 0, 1, 1);
    push(1, FAST_P, "R8"); push(1, -1, "R8"); push(3, SLOW_P, "R8"); drain();

    // R8 and R5: divided to pass-through
    start_cfg(mk(0, 1, 2, 1)); push(2, 2 * FAST_P, "R8"); drain();
    ctrl = mk(0, 1, 0, 1);
    push(1, 2 * FAST_P, "R8"); push(1, FAST_P, "R5"); push(1, 1, "R5");
    push(1, FAST_P - 1, "R5"); push(1, 1, "R5"); drain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule